// File: doc/BRIEF.md
# Descriptor-Chained Stream Engine

This block moves payload bytes into a packet FIFO by walking a chain of descriptors. The descriptors sit in a small memory that a CPU fills ahead of time. Software writes the index of the first descriptor into a start register, and the engine then runs on its own. For each descriptor it loads one descriptor word, moves `count+1` bytes, and then decides what to do next from four control flags. The bytes come either from a local data memory or from a live dataport stream.

A descriptor can close the packet being built. The engine then holds a commit request toward the FIFO until it is acknowledged. In this way a packet of any length is made from several chunks, with no length register to program. A descriptor can raise an interrupt pulse when it ends. It can also link to a further descriptor. A cancel from the dataport during a streamed descriptor stops the whole chain. Software then reads the busy flag and the byte counter to see how far the transfer got.

Top module: `dma_chain_streamer`

## Requirements
- R1: A pulse on `start_we` while idle launches the engine at the descriptor index given on `start_desc`, and `busy` is high from the next cycle on.
- R2: The descriptor word is laid out as follows: bit0 LINK, bit1 NOTIFY, bit2 CLOSE, bit3 STREAM, [7:4] next index, [15:8] count, [19:16] step, [27:20] source address. In memory mode the engine emits `count+1` bytes read from data memory at `source + k*step` (modulo 256), for k = 0 to count.
- R3: When STREAM is 1, the source and step fields are ignored, and `count+1` bytes are taken in order from the dataport.
- R4: When a descriptor finishes and NOTIFY is 1, `irq` is high for exactly one cycle. No pulse is raised when NOTIFY is 0.
- R5: After a descriptor finishes, LINK=1 makes the engine continue at the next index, and LINK=0 ends the chain.
- R6: When a descriptor with CLOSE=1 finishes, `pkt_commit` rises with no further payload beat. It stays high until `pkt_commit_ack`, and only then does the chain go on. The committed length is the number of bytes emitted since the previous commit.
- R7: `dp_cancel` during a STREAM descriptor stops the engine at once, whatever LINK says. No further bytes, commit or interrupt follow.
- R8: `cur_count` gives the number of bytes moved by the active or most recent descriptor. It restarts at 0 on each descriptor load and reports a partial count after a cancel.
- R9: `busy` is high exactly while a chain is in progress. It returns low after the final descriptor, or after a cancel.
- R10: The engine honours valid/ready on both the dataport and the packet side. A stall on either side loses and duplicates no byte, and in memory mode it holds `pkt_data` stable.
- R11: A `start_we` pulse while busy is ignored. It neither redirects the running chain nor starts a new one afterwards.
- R12: A synchronous reset returns the engine to idle with `busy`, `irq`, `pkt_valid`, `pkt_commit` and `dp_ready` low and `cur_count` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_we | input | 1 | Start register write strobe |
| start_desc | input | DAW | First descriptor index |
| busy | output | 1 | Engine active |
| cur_count | output | CW+1 | Bytes moved by current or last descriptor |
| irq | output | 1 | One-cycle completion interrupt |
| desc_we | input | 1 | Descriptor memory write enable |
| desc_waddr | input | DAW | Descriptor memory write index |
| desc_wdata | input | DESC_W | Descriptor word |
| mem_we | input | 1 | Data memory write enable |
| mem_waddr | input | AW | Data memory write address |
| mem_wdata | input | DW | Data memory write byte |
| dp_valid | input | 1 | Dataport byte available |
| dp_data | input | DW | Dataport byte |
| dp_cancel | input | 1 | Dataport premature end |
| dp_ready | output | 1 | Dataport byte consumed |
| pkt_valid | output | 1 | Payload byte valid toward packet FIFO |
| pkt_data | output | DW | Payload byte |
| pkt_ready | input | 1 | Packet FIFO accepts byte |
| pkt_commit | output | 1 | Packet commit request |
| pkt_commit_ack | input | 1 | Packet commit accepted |

## Verification
After a start pulse, the engine spends one cycle loading the descriptor, and only then can `pkt_valid` rise. `busy` is therefore checked one clock after the start strobe. A payload byte is counted in the same cycle in which `pkt_valid` and `pkt_ready` are both high.

`irq` and `pkt_commit` rise one edge after the last beat of a descriptor. `cur_count` is final at that same edge, and `busy` falls at that edge too, unless a commit or a link follows. The bench drives its inputs on the falling edge and reads the outputs shortly after it. Every observation therefore lands in the cycle in which the result is due. Streams, commit lengths and interrupt counts are collected per cycle and compared with a model once `busy` has dropped.

// File: rtl/dma_chain_streamer.sv
module dma_chain_streamer #(
  parameter int AW  = 8,
  parameter int DAW = 4,
  parameter int CW  = 8,
  parameter int IW  = 4,
  parameter int DW  = 8,
  localparam int DESC_W = AW + IW + CW + DAW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_we,
  input  logic [DAW-1:0]    start_desc,
  output logic              busy,
  output logic [CW:0]       cur_count,
  output logic              irq,
  input  logic              desc_we,
  input  logic [DAW-1:0]    desc_waddr,
  input  logic [DESC_W-1:0] desc_wdata,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_waddr,
  input  logic [DW-1:0]     mem_wdata,
  input  logic              dp_valid,
  input  logic [DW-1:0]     dp_data,
  input  logic              dp_cancel,
  output logic              dp_ready,
  output logic              pkt_valid,
  output logic [DW-1:0]     pkt_data,
  input  logic              pkt_ready,
  output logic              pkt_commit,
  input  logic              pkt_commit_ack
);
  localparam int NX_LSB  = 4;
  localparam int CNT_LSB = NX_LSB + DAW;
  localparam int INC_LSB = CNT_LSB + CW;
  localparam int PTR_LSB = INC_LSB + IW;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_XFER, S_FLUSH} state_t;

  logic [DESC_W-1:0] desc_mem [2**DAW];
  logic [DW-1:0]     data_mem [2**AW];

  state_t            state;
  logic [DAW-1:0]    desc_ptr;
  logic [DESC_W-1:0] cur;
  logic [AW-1:0]     addr;
  logic [CW-1:0]     remain;

  always_ff @(posedge clk) begin
    if (desc_we) desc_mem[desc_waddr] <= desc_wdata;
    if (mem_we)  data_mem[mem_waddr]  <= mem_wdata;
  end

  wire [DESC_W-1:0] ld     = desc_mem[desc_ptr];
  wire              c_link = cur[0];
  wire              c_note = cur[1];
  wire              c_close = cur[2];
  wire              c_strm = cur[3];
  wire [DAW-1:0]    c_next = cur[NX_LSB +: DAW];
  wire [IW-1:0]     c_step = cur[INC_LSB +: IW];

  wire xfer     = (state == S_XFER);
  wire dp_phase = xfer && c_strm;
  wire beat     = pkt_valid && pkt_ready;

  assign busy       = (state != S_IDLE);
  assign pkt_commit = (state == S_FLUSH);
  assign pkt_valid  = xfer && (c_strm ? (dp_valid && !dp_cancel) : 1'b1);
  assign pkt_data   = c_strm ? dp_data : data_mem[addr];
  assign dp_ready   = dp_phase && pkt_ready && !dp_cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      desc_ptr  <= '0;
      cur       <= '0;
      addr      <= '0;
      remain    <= '0;
      cur_count <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (start_we) begin
          desc_ptr <= start_desc;
          state    <= S_LOAD;
        end
        S_LOAD: begin
          cur       <= ld;
          addr      <= ld[PTR_LSB +: AW];
          remain    <= ld[CNT_LSB +: CW];
          cur_count <= '0;
          state     <= S_XFER;
        end
        S_XFER: begin
          if (dp_phase && dp_cancel) begin
            state <= S_IDLE;
          end else if (beat) begin
            cur_count <= cur_count + 1'b1;
            addr      <= addr + AW'(c_step);
            remain    <= remain - 1'b1;
            if (remain == '0) begin
              irq <= c_note;
              if (c_close) state <= S_FLUSH;
              else if (c_link) begin
                desc_ptr <= c_next;
                state    <= S_LOAD;
              end else state <= S_IDLE;
            end
          end
        end
        S_FLUSH: if (pkt_commit_ack) begin
          if (c_link) begin
            desc_ptr <= c_next;
            state    <= S_LOAD;
          end else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_chain_checker #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_we,
  input logic          busy,
  input logic          irq,
  input logic [CW:0]   cur_count,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [DW-1:0] pkt_data,
  input logic          pkt_commit,
  input logic          pkt_commit_ack,
  input logic          dp_cancel,
  input logic          dp_phase
);
  assert_start_launch_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_we) |=> busy);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_commit_no_beat_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_commit |-> !pkt_valid);

  assert_commit_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_commit && !pkt_commit_ack) |=> pkt_commit);

  assert_cancel_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (dp_phase && dp_cancel) |=> !busy);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> (cur_count == $past(cur_count) + 1'b1));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready && !dp_phase) |=> (pkt_valid && $stable(pkt_data)));
endmodule

bind dma_chain_streamer dma_chain_checker #(.CW(CW), .DW(DW)) i_chk (
  .clk(clk), .rst(rst), .start_we(start_we), .busy(busy), .irq(irq),
  .cur_count(cur_count), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_data(pkt_data), .pkt_commit(pkt_commit), .pkt_commit_ack(pkt_commit_ack),
  .dp_cancel(dp_cancel), .dp_phase(dp_phase)
);

// File: tb/test_dma_chain_streamer.sv
module test_dma_chain_streamer;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_we = 1'b0;
  logic [3:0] start_desc = '0;
  logic busy, irq, dp_ready, pkt_valid, pkt_commit;
  logic [8:0] cur_count;
  logic desc_we = 1'b0;
  logic [3:0] desc_waddr = '0;
  logic [27:0] desc_wdata = '0;
  logic mem_we = 1'b0;
  logic [7:0] mem_waddr = '0, mem_wdata = '0;
  logic dp_valid = 1'b0, dp_cancel = 1'b0, pkt_ready = 1'b0, pkt_commit_ack = 1'b0;
  logic [7:0] dp_data = '0;
  logic [7:0] pkt_data;

  dma_chain_streamer i_dma_chain_streamer (
    .clk(clk), .rst(rst), .start_we(start_we), .start_desc(start_desc),
    .busy(busy), .cur_count(cur_count), .irq(irq),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dp_valid(dp_valid), .dp_data(dp_data), .dp_cancel(dp_cancel), .dp_ready(dp_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
    .pkt_commit(pkt_commit), .pkt_commit_ack(pkt_commit_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [27:0] bdesc [16];
  logic [7:0]  bmem  [256];
  logic [7:0]  dp_src [1024];
  int dp_idx = 0;
  bit cancel_on = 0;
  int cancel_at = 0;

  logic [7:0] got_b [4096];
  logic [7:0] exp_b [4096];
  int got_n, exp_n, got_cn, exp_cn, got_irq, exp_irq, exp_last;
  int got_c [64];
  int exp_c [64];
  bit irq_prev = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [27:0] pack(int ptr, int inc, int cnt, int nxt,
                                       bit dp, bit fl, bit nt, bit ln);
    return {ptr[7:0], inc[3:0], cnt[7:0], nxt[3:0], dp, fl, nt, ln};
  endfunction

  task automatic wr_desc(int i, logic [27:0] d);
    @(negedge clk);
    desc_we = 1'b1; desc_waddr = i[3:0]; desc_wdata = d; bdesc[i] = d;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic build_exp(int s);
    int d = s, di = dp_idx, tot = 0;
    exp_n = 0; exp_cn = 0; exp_irq = 0; exp_last = 0;
    for (int g = 0; g < 16; g++) begin
      logic [27:0] w = bdesc[d];
      int cnt = w[15:8];
      for (int k = 0; k <= cnt; k++) begin
        if (w[3]) begin exp_b[exp_n] = dp_src[di]; di = (di + 1) % 1024; end
        else exp_b[exp_n] = bmem[(w[27:20] + k * w[19:16]) & 255];
        exp_n++; tot++;
      end
      exp_last = cnt + 1;
      if (w[1]) exp_irq++;
      if (w[2]) begin exp_c[exp_cn] = tot; exp_cn++; tot = 0; end
      if (!w[0]) break;
      d = w[7:4];
    end
  endtask

  task automatic clear_got();
    got_n = 0; got_cn = 0; got_irq = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      pkt_ready = ($urandom % 4) != 0;
      dp_valid  = ($urandom % 3) != 0;
      dp_data   = dp_src[dp_idx];
      dp_cancel = cancel_on && (dp_idx == cancel_at);
      pkt_commit_ack = ($urandom % 3) == 0;
      #1;
      if (pkt_valid && pkt_ready) begin
        got_b[got_n] = pkt_data; got_n++;
      end
      if (dp_ready && dp_valid) dp_idx = (dp_idx + 1) % 1024;
      if (pkt_commit && pkt_commit_ack) begin
        got_c[got_cn] = 0; got_cn++;
      end
      if (pkt_commit && pkt_valid) chk(0, "R6", "beat during commit", 1, 0);
      if (irq) begin
        got_irq++;
        if (irq_prev) chk(0, "R4", "irq longer than one cycle", 2, 1);
      end
      irq_prev = irq;
    end
  end

  int seg_start = 0;
  initial begin
    int last_tot = 0;
    forever begin
      @(negedge clk); #2;
      if (pkt_commit && pkt_commit_ack) begin
        got_c[got_cn-1] = got_n - seg_start;
        seg_start = got_n;
      end
    end
  end

  task automatic launch(int s);
    @(negedge clk);
    start_we = 1'b1; start_desc = s[3:0];
    @(negedge clk);
    start_we = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    #3;
  endtask

  task automatic compare(string tag);
    int bad = -1;
    chk(got_n == exp_n, "R2", {tag, " byte total"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got_b[i] !== exp_b[i] && bad < 0) bad = i;
    chk(bad < 0, "R3", {tag, " byte stream"}, bad < 0 ? 0 : got_b[bad], bad < 0 ? 0 : exp_b[bad]);
    chk(got_cn == exp_cn, "R6", {tag, " commit count"}, got_cn, exp_cn);
    for (int i = 0; i < exp_cn && i < got_cn; i++)
      chk(got_c[i] == exp_c[i], "R6", {tag, " commit length"}, got_c[i], exp_c[i]);
    chk(got_irq == exp_irq, "R4", {tag, " irq count"}, got_irq, exp_irq);
    chk(cur_count == exp_last, "R8", {tag, " cur_count"}, cur_count, exp_last);
    chk(busy == 1'b0, "R9", {tag, " busy after chain"}, busy, 0);
  endtask

  task automatic run(int s, string tag);
    clear_got(); seg_start = 0;
    build_exp(s);
    launch(s);
    wait_idle();
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) dp_src[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !irq && !pkt_valid && !pkt_commit && !dp_ready, "R12", "reset outputs", busy, 0);
    chk(cur_count == 0, "R12", "reset cur_count", cur_count, 0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'($urandom);
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = i[7:0]; mem_wdata = bmem[i];
    end
    @(negedge clk); mem_we = 1'b0;

    // R2 R4 R6: single memory descriptor, notify and close
    wr_desc(0, pack(10, 1, 7, 0, 0, 1, 1, 0));
    run(0, "R2 single");

    // R5 R3 R10: mixed chain with step 3, step 0, then streamed segment
    wr_desc(2, pack(200, 3, 5, 7, 0, 0, 0, 1));
    wr_desc(7, pack(50, 0, 2, 4, 0, 0, 1, 1));
    wr_desc(4, pack(170, 9, 6, 0, 1, 1, 0, 0));
    run(2, "R5 chain");

    // R6: two closes in one chain, continues after ack
    wr_desc(9, pack(30, 2, 3, 10, 0, 1, 0, 1));
    wr_desc(10, pack(90, 1, 0, 0, 0, 1, 1, 0));
    run(9, "R6 two packets");

    // R7: cancel mid-stream, link ignored
    wr_desc(11, pack(0, 0, 9, 12, 1, 1, 1, 1));
    wr_desc(12, pack(5, 1, 3, 0, 0, 1, 1, 0));
    clear_got(); seg_start = 0;
    cancel_at = (dp_idx + 4) % 1024;
    for (int i = 0; i < 4; i++) exp_b[i] = dp_src[(dp_idx + i) % 1024];
    cancel_on = 1;
    launch(11);
    wait_idle();
    cancel_on = 0;
    chk(got_n == 4, "R7", "bytes before cancel", got_n, 4);
    chk(got_b[0] == exp_b[0] && got_b[3] == exp_b[3], "R7", "cancel stream data", got_b[3], exp_b[3]);
    chk(got_cn == 0 && got_irq == 0, "R7", "no commit/irq after cancel", got_cn + got_irq, 0);
    chk(cur_count == 4, "R8", "partial count after cancel", cur_count, 4);
    chk(busy == 0, "R9", "idle after cancel", busy, 0);

    // R11: start while busy ignored
    wr_desc(0, pack(3, 1, 40, 5, 0, 0, 0, 0));
    wr_desc(5, pack(100, 2, 4, 0, 0, 1, 1, 0));
    clear_got(); seg_start = 0;
    build_exp(0);
    launch(0);
    repeat (10) @(negedge clk);
    start_we = 1'b1; start_desc = 4'd5;
    @(negedge clk); start_we = 1'b0;
    wait_idle();
    compare("R11 start while busy");
    repeat (3) @(negedge clk);
    #2;
    chk(busy == 0, "R11", "no deferred start", busy, 0);

    // R12: reset in mid-chain
    launch(0);
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #2;
    chk(!busy && !pkt_valid && !pkt_commit && !irq && !dp_ready, "R12", "reset mid-run outputs", busy, 0);
    chk(cur_count == 0, "R12", "reset mid-run cur_count", cur_count, 0);
    @(negedge clk); rst = 1'b0;

    // R10 R5 R3: constrained random chains
    for (int it = 0; it < 30; it++) begin
      int len = 1 + ($urandom % 4);
      for (int j = 0; j < len; j++) begin
        bit last = (j == len - 1);
        wr_desc(12 + j, pack($urandom % 256, $urandom % 16, $urandom % 16,
                             last ? 0 : 13 + j, $urandom % 2, last ? 1 : ($urandom % 2),
                             $urandom % 2, !last));
      end
      run(12, "R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule